// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller Pair

This block joins two eight-input priority interrupt controllers into one unit. The primary controller serves request lines 0 to 7. The secondary controller serves lines 8 to 15, and its own request drives input 2 of the primary. The bit 3 of a line number therefore picks the controller. The pair reduces its sixteen request lines to a single processor interrupt, `cpu_int`.

The processor answers with a one-cycle acknowledge. In that same cycle the block returns an 8-bit vector and moves the winning line from pending to in-service. `cpu_int` behaves like a valid flag and `int_ack` like an accept. There is no back-pressure on the vector: it is valid only in the cycle in which `int_ack` is high, and it must be taken then.

Software uses a byte-wide register port with three addresses:
- The command address takes the start-of-initialization word and the end-of-interrupt, priority and read-select commands. A read from it returns pending, in-service or a poll result.
- The data address takes the remaining initialization words. After initialization it holds the mask.
- The trigger address holds the per-line edge/level select.

Priority is circular. Offset k gives line k the highest priority, followed by k+1, and so on modulo 8.

Top module: `pic_cascade_pair`

## Requirements
- R1: Lines 0–7 request on the primary and lines 8–15 on the secondary. Whenever the secondary has a winner, the primary's pending bit 2 is set, one clock later. The external pin for line 2 is ignored.
- R2: A controller has a winner when some pending, unmasked line outranks everything in service. Rank is measured circularly from the priority offset. `cpu_int` is high exactly when the primary has a winner. The mask is written and read at the data address (address 1) once initialization has finished. A mask bit at 1 blocks its line.
- R3: When `int_ack` is high and the primary has a non-cascade winner, `int_vector` in that cycle equals {primary base, line}. On the following edge the line's in-service bit is set and its pending bit is cleared.
- R4: When the primary's winner is line 2, the secondary is acknowledged in the same cycle and the vector is {secondary base, secondary line}. If the secondary has no winner, the vector is {secondary base, 7}.
- R5: An acknowledge with no primary winner returns {primary base, 7} and changes no state.
- R6: The base keeps only bits 7:3 of the byte written as the second initialization word. Bits 2:0 of a vector always come from the line number.
- R7: A command-address byte with bits 4:3 = 00 carries an operation in bits 7:5 and a line in bits 2:0:
  - 1 clears the highest-ranked in-service bit.
  - 3 clears the named bit.
  - 5 does what 1 does and sets the offset to that line + 1.
  - 6 sets the offset to the line + 1.
  - 7 clears the named bit and sets the offset to line + 1.

  All arithmetic is modulo 8.
- R8: Bit 4 of the fourth initialization word enables nested-cascade mode on the primary. In that mode, in-service bit 2 is disregarded when the primary ranks current service, so a higher secondary request can interrupt a secondary handler.
- R9: A command-address byte with bit 4 set starts initialization. It clears pending, in-service, mask, offset, base, edge/level select and the read modes. `cpu_int` is low in the next cycle. The following data writes are the base word, then the cascade word, then a mode word only if bit 0 of the start word was 1. After that, data writes go to the mask.
- R10: The trigger address (address 2) stores the written byte ANDed with 0xF8 on the primary and 0xDE on the secondary.
  - A line whose select bit is 1 is level-triggered: its pending bit follows the pin each cycle.
  - Otherwise the line is edge-triggered: a rising pin sets the pending bit, and the bit stays set until it is acknowledged.
- R11: A command-address byte with bits 4:3 = 01 and bit 2 set arms a poll. The next command-address read returns the winning line and clears that line's pending and in-service bits, or returns 7 if there is no winner. A poll of the secondary that finds a winner also clears the primary's pending and in-service bit 2.
- R12: In a command byte with bits 4:3 = 01, bit 1 set selects the source for non-poll reads at the command address: bit 0 = 1 selects in-service, bit 0 = 0 selects pending.
- R13: After reset, all registers are zero, `cpu_int` is low and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | 16 | Request lines; 0–7 primary, 8–15 secondary |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (poll side effects) |
| reg_sel | input | 1 | 0 primary, 1 secondary |
| reg_addr | input | 2 | 0 command, 1 data, 2 trigger select |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Read byte, combinational |
| cpu_int | output | 1 | Processor interrupt request |
| int_ack | input | 1 | Single-cycle acknowledge |
| int_vector | output | 8 | Vector, valid in the acknowledge cycle |

## Verification
A vector table sets up several request patterns and checks the acknowledged vector for each:
- single primary lines;
- two primary lines at once, where the lower number wins;
- single secondary lines, which separate cascade routing from direct routing;
- line 1 against line 10, and line 3 against line 10, which place the cascade input correctly in the primary order;
- two secondary lines at once;
- the bare line-2 pin and an idle bus, which both give the spurious vector.

Directed sequences then check the following:
- Rotation and set-priority, by pending two lines whose winner flips with the offset.
- Nested-cascade mode, by requesting a higher secondary line while a secondary handler is in service, first with the mode on and then with it off.
- Level triggering against edge triggering, by dropping a line before it is acknowledged.
- Primary and secondary polls, and the spurious secondary vector under a mask.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int LINES  = 8;
  localparam int IDX_W  = $clog2(LINES);
  localparam int BASE_W = 8 - IDX_W;

  typedef logic [LINES-1:0] line_vec_t;
  typedef logic [IDX_W-1:0] line_idx_t;
  typedef logic [BASE_W-1:0] base_t;

  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_BASE = 2'd1,
    PH_CASC = 2'd2,
    PH_MODE = 2'd3
  } init_phase_t;

  typedef enum logic [2:0] {
    OP_NONE        = 3'd0,
    OP_CLR_TOP     = 3'd1,
    OP_CLR_NAMED   = 3'd3,
    OP_CLR_TOP_ROT = 3'd5,
    OP_SET_OFFSET  = 3'd6,
    OP_CLR_NAMED_ROT = 3'd7
  } end_op_t;

  localparam logic [1:0] ADDR_CMD  = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_TRIG = 2'd2;
endpackage

// File: rtl/pic_rot_first.sv
module pic_rot_first #(
  parameter int N = 8
) (
  input  logic [N-1:0]         vec,
  input  logic [$clog2(N)-1:0] offset,
  output logic                 found,
  output logic [$clog2(N)-1:0] rank,
  output logic [$clog2(N)-1:0] idx
);
  localparam int W = $clog2(N);

  logic [W-1:0] pos;

  // Scan from the lowest rank last so the smallest rank wins.
  always_comb begin
    found = 1'b0;
    rank  = '0;
    idx   = '0;
    pos   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      pos = offset + W'(k);
      if (vec[pos]) begin
        found = 1'b1;
        rank  = W'(k);
        idx   = pos;
      end
    end
  end
endmodule

// File: rtl/pic_unit.sv
module pic_unit
  import pic_pkg::*;
#(
  parameter bit        PRIMARY   = 1'b1,
  parameter logic [7:0] TRIG_MASK = 8'hF8,
  parameter int        CASC      = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t line_in,
  input  line_vec_t pulse_in,
  input  logic      wr,
  input  logic      rd,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  input  logic      ack,
  input  logic      ext_clr,
  output logic [7:0] rdata,
  output logic      win_valid,
  output line_idx_t win_idx,
  output base_t     base_o,
  output line_vec_t irr_o,
  output line_vec_t isr_o,
  output line_vec_t imr_o,
  output logic      poll_clr
);
  localparam line_vec_t CASC_BIT = line_vec_t'(1) << CASC;
  localparam line_idx_t LAST_IDX = line_idx_t'(LINES - 1);

  line_vec_t   irr, isr, imr, last, trig;
  line_vec_t   irr_n, isr_n, edge_set;
  line_vec_t   pend, busy;
  base_t       base;
  line_idx_t   offset;
  init_phase_t phase;
  logic        want_mode, nested, rd_isr, poll;

  logic        p_found, b_found, e_found;
  line_idx_t   p_rank, b_rank, e_rank, p_idx, b_idx, e_idx;

  logic        cmd_wr, start_wr, sel_wr, op_wr, data_wr, trig_wr, poll_rd;
  end_op_t     op;
  line_idx_t   lvl;

  assign cmd_wr   = wr && (addr == ADDR_CMD);
  assign start_wr = cmd_wr && wdata[4];
  assign sel_wr   = cmd_wr && !wdata[4] && wdata[3];
  assign op_wr    = cmd_wr && !wdata[4] && !wdata[3];
  assign data_wr  = wr && (addr == ADDR_DATA);
  assign trig_wr  = wr && (addr == ADDR_TRIG);
  assign poll_rd  = rd && (addr == ADDR_CMD) && poll;
  assign op       = end_op_t'(wdata[7:5]);
  assign lvl      = wdata[IDX_W-1:0];

  assign pend = irr & ~imr;
  assign busy = (PRIMARY && nested) ? (isr & ~CASC_BIT) : isr;

  pic_rot_first #(.N(LINES)) i_pend_rank (
    .vec(pend), .offset(offset), .found(p_found), .rank(p_rank), .idx(p_idx));
  pic_rot_first #(.N(LINES)) i_busy_rank (
    .vec(busy), .offset(offset), .found(b_found), .rank(b_rank), .idx(b_idx));
  pic_rot_first #(.N(LINES)) i_eoi_rank (
    .vec(isr), .offset(offset), .found(e_found), .rank(e_rank), .idx(e_idx));

  assign win_valid = p_found && (!b_found || (p_rank < b_rank));
  assign win_idx   = p_idx;
  assign poll_clr  = poll_rd && win_valid;

  // Per-line edge detector; level lines are handled in the next-state logic.
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign edge_set[i] = line_in[i] && !last[i];
  end

  always_comb begin
    irr_n = irr;
    isr_n = isr;
    for (int i = 0; i < LINES; i++) begin
      if (trig[i]) irr_n[i] = line_in[i];
      else if (edge_set[i]) irr_n[i] = 1'b1;
    end
    irr_n = irr_n | pulse_in;
    if (ack && win_valid) begin
      irr_n[win_idx] = 1'b0;
      isr_n[win_idx] = 1'b1;
    end
    if (poll_clr) begin
      irr_n[win_idx] = 1'b0;
      isr_n[win_idx] = 1'b0;
    end
    if (ext_clr) begin
      irr_n = irr_n & ~CASC_BIT;
      isr_n = isr_n & ~CASC_BIT;
    end
    if (op_wr) begin
      case (op)
        OP_CLR_TOP, OP_CLR_TOP_ROT: if (e_found) isr_n[e_idx] = 1'b0;
        OP_CLR_NAMED, OP_CLR_NAMED_ROT: isr_n[lvl] = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr <= '0; isr <= '0; imr <= '0; last <= '0; trig <= '0;
      base <= '0; offset <= '0; phase <= PH_RUN;
      want_mode <= 1'b0; nested <= 1'b0; rd_isr <= 1'b0; poll <= 1'b0;
    end else if (start_wr) begin
      irr <= '0; isr <= '0; imr <= '0; last <= '0; trig <= '0;
      base <= '0; offset <= '0; phase <= PH_BASE;
      want_mode <= wdata[0]; nested <= 1'b0; rd_isr <= 1'b0; poll <= 1'b0;
    end else begin
      irr  <= irr_n;
      isr  <= isr_n;
      last <= line_in;
      if (poll_rd) poll <= 1'b0;
      if (op_wr) begin
        case (op)
          OP_CLR_TOP_ROT:   if (e_found) offset <= e_idx + 1'b1;
          OP_SET_OFFSET, OP_CLR_NAMED_ROT: offset <= lvl + 1'b1;
          default: ;
        endcase
      end
      if (sel_wr) begin
        if (wdata[2]) poll <= 1'b1;
        if (wdata[1]) rd_isr <= wdata[0];
      end
      if (data_wr) begin
        case (phase)
          PH_RUN:  imr <= wdata;
          PH_BASE: begin
            base  <= wdata[7:IDX_W];
            phase <= PH_CASC;
          end
          PH_CASC: phase <= want_mode ? PH_MODE : PH_RUN;
          PH_MODE: begin
            nested <= wdata[4];
            phase  <= PH_RUN;
          end
          default: phase <= PH_RUN;
        endcase
      end
      if (trig_wr) trig <= wdata & TRIG_MASK;
    end
  end

  always_comb begin
    case (addr)
      ADDR_CMD: begin
        if (poll) rdata = win_valid ? 8'(win_idx) : 8'(LAST_IDX);
        else      rdata = rd_isr ? 8'(isr) : 8'(irr);
      end
      ADDR_DATA: rdata = 8'(imr);
      ADDR_TRIG: rdata = 8'(trig);
      default:   rdata = 8'h00;
    endcase
  end

  assign base_o = base;
  assign irr_o  = irr;
  assign isr_o  = isr;
  assign imr_o  = imr;
endmodule

// File: rtl/pic_cascade_pair.sv
module pic_cascade_pair
  import pic_pkg::*;
#(
  parameter logic [7:0] PRI_TRIG_MASK = 8'hF8,
  parameter logic [7:0] SEC_TRIG_MASK = 8'hDE,
  parameter int         CASC_LINE     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*LINES-1:0]   irq_lines,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic                 reg_sel,
  input  logic [1:0]           reg_addr,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  output logic                 cpu_int,
  input  logic                 int_ack,
  output logic [7:0]           int_vector
);
  localparam line_vec_t CASC_BIT = line_vec_t'(1) << CASC_LINE;
  localparam line_idx_t CASC_IDX = line_idx_t'(CASC_LINE);
  localparam line_idx_t LAST_IDX = line_idx_t'(LINES - 1);

  line_vec_t m_lines, s_lines, m_pulse;
  logic [7:0] m_rdata, s_rdata;
  logic      m_win_valid, s_win_valid, m_poll_clr, s_poll_clr, s_ack;
  line_idx_t m_win_idx, s_win_idx;
  base_t     m_base, s_base;
  line_vec_t m_irr, m_isr, m_imr, s_irr, s_isr, s_imr;

  assign m_lines = irq_lines[LINES-1:0] & ~CASC_BIT;
  assign s_lines = irq_lines[2*LINES-1:LINES];
  assign m_pulse = s_win_valid ? CASC_BIT : '0;
  assign s_ack   = int_ack && m_win_valid && (m_win_idx == CASC_IDX);

  pic_unit #(.PRIMARY(1'b1), .TRIG_MASK(PRI_TRIG_MASK), .CASC(CASC_LINE)) i_primary (
    .clk(clk), .rst_n(rst_n), .line_in(m_lines), .pulse_in(m_pulse),
    .wr(reg_wr && !reg_sel), .rd(reg_rd && !reg_sel), .addr(reg_addr),
    .wdata(reg_wdata), .ack(int_ack), .ext_clr(s_poll_clr),
    .rdata(m_rdata), .win_valid(m_win_valid), .win_idx(m_win_idx),
    .base_o(m_base), .irr_o(m_irr), .isr_o(m_isr), .imr_o(m_imr),
    .poll_clr(m_poll_clr));

  pic_unit #(.PRIMARY(1'b0), .TRIG_MASK(SEC_TRIG_MASK), .CASC(CASC_LINE)) i_secondary (
    .clk(clk), .rst_n(rst_n), .line_in(s_lines), .pulse_in('0),
    .wr(reg_wr && reg_sel), .rd(reg_rd && reg_sel), .addr(reg_addr),
    .wdata(reg_wdata), .ack(s_ack), .ext_clr(1'b0),
    .rdata(s_rdata), .win_valid(s_win_valid), .win_idx(s_win_idx),
    .base_o(s_base), .irr_o(s_irr), .isr_o(s_isr), .imr_o(s_imr),
    .poll_clr(s_poll_clr));

  always_comb begin
    if (!m_win_valid)              int_vector = {m_base, LAST_IDX};
    else if (m_win_idx != CASC_IDX) int_vector = {m_base, m_win_idx};
    else if (s_win_valid)          int_vector = {s_base, s_win_idx};
    else                           int_vector = {s_base, LAST_IDX};
  end

  assign cpu_int   = m_win_valid;
  assign reg_rdata = reg_sel ? s_rdata : m_rdata;
endmodule

// File: rtl/pic_pair_checker.sv
module pic_pair_checker
  import pic_pkg::*;
#(
  parameter int CASC_LINE = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic       reg_sel,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       cpu_int,
  input logic       int_ack,
  input logic [7:0] int_vector,
  input logic       m_win_valid,
  input line_idx_t  m_win_idx,
  input logic       s_win_valid,
  input line_idx_t  s_win_idx,
  input line_vec_t  m_irr,
  input line_vec_t  m_imr,
  input line_vec_t  m_isr,
  input line_vec_t  s_irr,
  input line_vec_t  s_imr,
  input line_vec_t  s_isr,
  input logic       m_poll_clr
);
  localparam line_idx_t CASC_IDX = line_idx_t'(CASC_LINE);

  p_int_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && reg_addr == ADDR_CMD && reg_wdata[4]) |=> !cpu_int);

  p_spurious_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !cpu_int) |-> (int_vector[IDX_W-1:0] == line_idx_t'(LINES - 1)));

  p_ack_in_service_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && m_win_valid && !reg_wr && !reg_rd) |=> m_isr[$past(m_win_idx)]);

  p_cascade_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && m_win_valid && m_win_idx == CASC_IDX && s_win_valid && !reg_wr && !reg_rd)
      |=> s_isr[$past(s_win_idx)]);

  p_int_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_int |-> ((m_irr & ~m_imr) != '0));

  p_sec_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    s_win_valid |-> ((s_irr & ~s_imr) != '0));

  p_poll_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_poll_clr && !int_ack && !reg_wr) |=> !m_isr[$past(m_win_idx)]);
endmodule

bind pic_cascade_pair pic_pair_checker #(.CASC_LINE(CASC_LINE)) i_pair_checker (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .cpu_int(cpu_int), .int_ack(int_ack),
  .int_vector(int_vector), .m_win_valid(m_win_valid), .m_win_idx(m_win_idx),
  .s_win_valid(s_win_valid), .s_win_idx(s_win_idx), .m_irr(m_irr), .m_imr(m_imr),
  .m_isr(m_isr), .s_irr(s_irr), .s_imr(s_imr), .s_isr(s_isr), .m_poll_clr(m_poll_clr));

// File: tb/test_pic_cascade_pair.sv
`timescale 1ns/1ps
module test_pic_cascade_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_lines = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        cpu_int;
  logic        int_ack = 1'b0;
  logic [7:0]  int_vector;

  int n_checks = 0;
  int n_errors = 0;
  logic [7:0] v;

  always #10 clk = ~clk;

  pic_cascade_pair i_pic_cascade_pair (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_int(cpu_int),
    .int_ack(int_ack), .int_vector(int_vector));

  // {lines[15:0], expected cpu_int, expected vector}
  localparam logic [24:0] VEC_TABLE [10] = '{
    {16'h0001, 1'b1, 8'h20},
    {16'h0028, 1'b1, 8'h23},
    {16'h0400, 1'b1, 8'h2A},
    {16'h8000, 1'b1, 8'h2F},
    {16'h0402, 1'b1, 8'h21},
    {16'h0408, 1'b1, 8'h2A},
    {16'hC000, 1'b1, 8'h2E},
    {16'h0080, 1'b1, 8'h27},
    {16'h0004, 1'b0, 8'h27},
    {16'h0000, 1'b0, 8'h27}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic sel, input logic [1:0] a, input logic [7:0] d);
    reg_sel = sel; reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic get(input logic sel, input logic [1:0] a, output logic [7:0] d);
    reg_sel = sel; reg_addr = a; reg_rd = 1'b1;
    #5 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic take_ack(output logic [7:0] d);
    int_ack = 1'b1;
    #5 d = int_vector;
    @(negedge clk);
    int_ack = 1'b0;
  endtask

  task automatic init_one(input logic sel, input logic [7:0] base, input logic [7:0] mode);
    put(sel, 2'd0, 8'h11);
    put(sel, 2'd1, base);
    put(sel, 2'd1, sel ? 8'h02 : 8'h04);
    put(sel, 2'd1, mode);
  endtask

  task automatic init_both(input logic [7:0] pri_mode);
    irq_lines = '0;
    init_one(1'b0, 8'h20, pri_mode);
    init_one(1'b1, 8'h28, 8'h00);
    settle(1);
  endtask

  task automatic read_isr(input logic sel, output logic [7:0] d);
    put(sel, 2'd0, 8'h0B);
    get(sel, 2'd0, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(1);
    // R13 reset state
    check("R13 cpu_int after reset", {7'd0, cpu_int}, 8'h00);
    get(1'b0, 2'd0, v); check("R13 pending after reset", v, 8'h00);
    get(1'b0, 2'd1, v); check("R13 mask after reset", v, 8'h00);

    // Table: R1 R2 routing and order, R3 R4 R5 vectors
    for (int i = 0; i < 10; i++) begin
      init_both(8'h00);
      irq_lines = VEC_TABLE[i][24:9];
      settle(3);
      check($sformatf("R1 R2 table %0d cpu_int", i), {7'd0, cpu_int}, {7'd0, VEC_TABLE[i][8]});
      take_ack(v);
      check($sformatf("R3 R4 R5 table %0d vector", i), v, VEC_TABLE[i][7:0]);
    end

    // R6 base low bits dropped
    irq_lines = '0;
    init_one(1'b0, 8'h2F, 8'h00);
    init_one(1'b1, 8'h28, 8'h00);
    irq_lines = 16'h0001; settle(2);
    take_ack(v); check("R6 base bits", v, 8'h28);

    // R2 mask blocks, unmask releases latched request
    init_both(8'h00);
    put(1'b0, 2'd1, 8'h01);
    irq_lines = 16'h0001; settle(3);
    check("R2 masked line", {7'd0, cpu_int}, 8'h00);
    get(1'b0, 2'd1, v); check("R2 mask readback", v, 8'h01);
    put(1'b0, 2'd1, 8'h00); settle(1);
    check("R2 unmasked line", {7'd0, cpu_int}, 8'h01);

    // R3 R12 in-service contents after cascade ack
    init_both(8'h00);
    irq_lines = 16'h0400; settle(3);
    take_ack(v); check("R4 cascade vector", v, 8'h2A);
    read_isr(1'b0, v); check("R12 primary in-service", v, 8'h04);
    read_isr(1'b1, v); check("R3 secondary in-service", v, 8'h04);
    put(1'b0, 2'd0, 8'h0A); get(1'b0, 2'd0, v); check("R3 primary pending cleared", v, 8'h00);

    // R2 nesting, then R7 end-of-interrupt forms
    init_both(8'h00);
    irq_lines = 16'h0008; settle(2); take_ack(v);
    irq_lines = 16'h0028; settle(2);
    check("R2 lower line blocked", {7'd0, cpu_int}, 8'h00);
    irq_lines = 16'h002A; settle(2);
    check("R2 higher line nests", {7'd0, cpu_int}, 8'h01);
    take_ack(v); check("R2 nested vector", v, 8'h21);
    put(1'b0, 2'd0, 8'h20);
    read_isr(1'b0, v); check("R7 clear top in-service", v, 8'h08);
    put(1'b0, 2'd0, 8'h63);
    read_isr(1'b0, v); check("R7 clear named", v, 8'h00);
    check("R7 pending fires after clear", {7'd0, cpu_int}, 8'h01);
    take_ack(v); check("R7 pending vector", v, 8'h25);

    // R7 rotate on clear-top
    init_both(8'h00);
    irq_lines = 16'h0008; settle(2); take_ack(v);
    put(1'b0, 2'd0, 8'hA0);
    irq_lines = 16'h0029; settle(2);
    take_ack(v); check("R7 rotated winner", v, 8'h25);
    settle(1);
    check("R7 line 0 below rotated service", {7'd0, cpu_int}, 8'h00);

    // R7 set offset
    init_both(8'h00);
    put(1'b0, 2'd0, 8'hC5);
    irq_lines = 16'h0041; settle(2);
    take_ack(v); check("R7 set offset winner", v, 8'h26);

    // R7 clear named with rotate
    init_both(8'h00);
    irq_lines = 16'h0008; settle(2); take_ack(v);
    put(1'b0, 2'd0, 8'hE3);
    irq_lines = 16'h0019; settle(2);
    take_ack(v); check("R7 named rotate winner", v, 8'h24);

    // R8 nested-cascade mode on, then off
    init_both(8'h10);
    irq_lines = 16'h0400; settle(3); take_ack(v);
    irq_lines = 16'h0600; settle(3);
    check("R8 nested mode cpu_int", {7'd0, cpu_int}, 8'h01);
    take_ack(v); check("R8 nested mode vector", v, 8'h29);
    init_both(8'h00);
    irq_lines = 16'h0400; settle(3); take_ack(v);
    irq_lines = 16'h0600; settle(3);
    check("R8 plain mode blocks", {7'd0, cpu_int}, 8'h00);

    // R4 spurious secondary vector
    init_both(8'h00);
    irq_lines = 16'h0400; settle(3);
    put(1'b1, 2'd1, 8'h04); settle(2);
    check("R4 cascade pending held", {7'd0, cpu_int}, 8'h01);
    take_ack(v); check("R4 spurious secondary", v, 8'h2F);

    // R5 spurious primary, no state change
    init_both(8'h00);
    take_ack(v); check("R5 spurious primary", v, 8'h27);
    read_isr(1'b0, v); check("R5 no in-service set", v, 8'h00);

    // R10 trigger select masks and level vs edge
    put(1'b0, 2'd2, 8'hFF); get(1'b0, 2'd2, v); check("R10 primary select mask", v, 8'hF8);
    put(1'b1, 2'd2, 8'hFF); get(1'b1, 2'd2, v); check("R10 secondary select mask", v, 8'hDE);
    init_both(8'h00);
    put(1'b0, 2'd2, 8'h08);
    irq_lines = 16'h0008; settle(2);
    check("R10 level request", {7'd0, cpu_int}, 8'h01);
    irq_lines = 16'h0000; settle(2);
    check("R10 level drop", {7'd0, cpu_int}, 8'h00);
    put(1'b0, 2'd2, 8'h00);
    irq_lines = 16'h0008; settle(2);
    irq_lines = 16'h0000; settle(2);
    check("R10 edge held", {7'd0, cpu_int}, 8'h01);

    // R11 polls
    init_both(8'h00);
    irq_lines = 16'h0010; settle(2);
    put(1'b0, 2'd0, 8'h0C); get(1'b0, 2'd0, v);
    check("R11 poll winner", v, 8'h04);
    check("R11 poll cleared request", {7'd0, cpu_int}, 8'h00);
    put(1'b0, 2'd0, 8'h0C); get(1'b0, 2'd0, v);
    check("R11 poll idle", v, 8'h07);
    init_both(8'h00);
    irq_lines = 16'h0800; settle(3);
    check("R1 secondary raises cpu_int", {7'd0, cpu_int}, 8'h01);
    put(1'b1, 2'd0, 8'h0C); get(1'b1, 2'd0, v);
    check("R11 secondary poll", v, 8'h03);
    settle(1);
    check("R11 secondary poll clears cascade", {7'd0, cpu_int}, 8'h00);

    // R9 start word drops cpu_int; bit0 clear skips mode word
    init_both(8'h00);
    irq_lines = 16'h0001; settle(2);
    check("R9 request before start", {7'd0, cpu_int}, 8'h01);
    put(1'b0, 2'd0, 8'h10);
    check("R9 cpu_int low after start", {7'd0, cpu_int}, 8'h00);
    put(1'b0, 2'd1, 8'h20);
    put(1'b0, 2'd1, 8'h04);
    put(1'b0, 2'd1, 8'h55);
    get(1'b0, 2'd1, v); check("R9 no mode word, mask written", v, 8'h55);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule